// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt events for a small 8-bit CPU core and presents one request at a time, together with the address of that request's vector slot. It takes single-cycle event pulses from on-chip peripherals, five asynchronous pins with selectable edge polarity, an 8-bit key port, and a software-break strobe. Each maskable source has a request bit and an enable bit. The CPU's global disable flag gates all maskable sources. When several requests are pending, the one at the lowest level number wins. The CPU acknowledges the request it is servicing.

There are seventeen levels. Level 1 is the reset slot. It is pending after reset and ignores every mask. Level 17 is the software break, which has no request or enable bit and cannot be masked. Levels 8 and 16 are each shared between two sources. A source-select register picks which source feeds each of these levels, and a capture register records which of the four shared sources fired. Software reaches all registers through a small synchronous write, combinational read bus.

Top module: `prio_vic`

## Requirements
- R1: After reset, all request bits, enable bits, the polarity register, the source-select register and the capture register read 0. Level 1 is presented (`irq`=1, `irq_lvl`=1, `irq_vec`=16'hFFFC) even when `gdis`=1. An acknowledge removes it.
- R2: While `irq`=1, `irq_vec` equals 16'hFFFE minus twice `irq_lvl`, so the vectors run from 16'hFFFC at level 1 down to 16'hFFDC at level 17. While `irq`=0, `irq_lvl` and `irq_vec` are 0.
- R3: A maskable level (2..16) is presented only when `gdis`=0 and both its request bit and its enable bit are 1.
- R4: Of all eligible levels, the lowest level number is presented first.
- R5: Once `irq` rises, `irq_lvl` and `irq_vec` hold until `ack`. In the cycle after `ack`, `irq` is 0. The acknowledge clears only the request of the level being serviced.
- R6: A request bit is set by its event and stays set until it is acknowledged or cleared by writing 1 to it. Request bit n-2 holds level n. Address 0 holds levels 2..9 and address 1 holds levels 10..16. Enables use the same layout at addresses 2 and 3.
- R7: Pins `pin_in[0..4]` feed levels 6, 7, 9, 10 and 11. Each pin passes through a two-flop synchronizer. Polarity bit k at address 4 selects the edge: 0 for falling, 1 for rising. The opposite edge is ignored.
- R8: The key event is a falling edge of the AND of all `key_in` bits, after synchronization.
- R9: At address 5, bit 0 selects the level-8 source (0 = key event, 1 = `pulse_in[4]`) and bit 1 selects the level-16 source (0 = `pulse_in[9]`, 1 = `pulse_in[10]`). The unselected source sets no request. The other pulse inputs map as follows: `pulse_in[0..3]` to levels 2 to 5, and `pulse_in[5..8]` to levels 12 to 15.
- R10: At address 6, the capture register sets bit 0 on a key event, bit 1 on `pulse_in[4]`, bit 2 on `pulse_in[9]` and bit 3 on `pulse_in[10]`, whatever the selection. Writing 1 to a bit clears it.
- R11: `brk_in` makes level 17 pending, regardless of `gdis` and of any enable bit, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 11 | One-cycle peripheral event pulses |
| pin_in | input | 5 | Asynchronous edge-triggered pins |
| key_in | input | 8 | Key port levels |
| brk_in | input | 1 | Software-break strobe |
| gdis | input | 1 | CPU global interrupt-disable flag |
| ack | input | 1 | CPU acknowledge of the presented level |
| wr | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Request to the CPU |
| irq_lvl | output | 5 | Presented level, 1..17 |
| irq_vec | output | 16 | Vector slot address |

## Verification
The bench builds the block with its default widths: 11 pulse inputs, 5 pins and an 8-bit key port. With these widths every one of the seventeen levels is reachable, along with both shared slots under both select values. A vector table walks each pulse source and each shared-slot choice. Directed tests then cover the reset slot, masking, priority order, hold-until-acknowledge, both pin polarities, the key event, the capture register and the break bypassing the disable flag.

// File: rtl/prio_vic.sv
module prio_vic #(
  parameter int NPULSE = 11,
  parameter int NPIN   = 5,
  parameter int NKEY   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPULSE-1:0] pulse_in,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NKEY-1:0]   key_in,
  input  logic              brk_in,
  input  logic              gdis,
  input  logic              ack,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic [4:0]        irq_lvl,
  output logic [15:0]       irq_vec
);
  localparam int NLVL = 17;
  localparam int NMSK = NLVL - 2;

  logic [NPIN-1:0] pin_s1, pin_s2, pin_pv, pol;
  logic [NKEY-1:0] key_s1, key_s2;
  logic            key_pv, rst_pend, brk_pend, active;
  logic [NMSK-1:0] req, en, set_v, ack_clr, w1c;
  logic [1:0]      sel;
  logic [3:0]      disc;
  logic [4:0]      cur, win;
  logic [NLVL-1:0] cand;

  wire [NPIN-1:0] pin_edge = (pin_s2 ^ pin_pv) & ~(pin_s2 ^ pol);
  wire            key_fall = key_pv & ~(&key_s2);
  wire            fire_ack = ack & active;

  assign set_v = { sel[1] ? pulse_in[10] : pulse_in[9],
                   pulse_in[8:5], pin_edge[4:2],
                   sel[0] ? pulse_in[4] : key_fall,
                   pin_edge[1:0], pulse_in[3:0] };

  assign cand = {brk_pend, req & en & {NMSK{~gdis}}, rst_pend};

  always_comb begin
    win = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (cand[i]) win = 5'(i + 1);
  end

  always_comb begin
    for (int i = 0; i < NMSK; i++) ack_clr[i] = fire_ack && (cur == 5'(i + 2));
    w1c = '0;
    if (wr && addr == 3'd0) w1c[7:0] = wdata;
    if (wr && addr == 3'd1) w1c[NMSK-1:8] = wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0; pin_s2 <= '0; pin_pv <= '0;
      key_s1 <= '1; key_s2 <= '1; key_pv <= 1'b1;
      req <= '0; en <= '0; pol <= '0; sel <= '0; disc <= '0;
      rst_pend <= 1'b1; brk_pend <= 1'b0; active <= 1'b0; cur <= '0;
    end else begin
      pin_s1 <= pin_in; pin_s2 <= pin_s1; pin_pv <= pin_s2;
      key_s1 <= key_in; key_s2 <= key_s1; key_pv <= &key_s2;
      req <= (req & ~w1c & ~ack_clr) | set_v;
      if (wr && addr == 3'd2) en[7:0]      <= wdata;
      if (wr && addr == 3'd3) en[NMSK-1:8] <= wdata[6:0];
      if (wr && addr == 3'd4) pol          <= wdata[NPIN-1:0];
      if (wr && addr == 3'd5) sel          <= wdata[1:0];
      disc <= (disc & ~((wr && addr == 3'd6) ? wdata[3:0] : 4'd0))
            | {pulse_in[10], pulse_in[9], pulse_in[4], key_fall};
      if (fire_ack && cur == 5'd1) rst_pend <= 1'b0;
      if (brk_in) brk_pend <= 1'b1;
      else if (fire_ack && cur == 5'(NLVL)) brk_pend <= 1'b0;
      if (fire_ack) active <= 1'b0;
      else if (!active && win != '0) begin
        active <= 1'b1;
        cur    <= win;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = req[7:0];
      3'd1:    rdata = {1'b0, req[NMSK-1:8]};
      3'd2:    rdata = en[7:0];
      3'd3:    rdata = {1'b0, en[NMSK-1:8]};
      3'd4:    rdata = 8'(pol);
      3'd5:    rdata = {6'd0, sel};
      3'd6:    rdata = {4'd0, disc};
      default: rdata = 8'd0;
    endcase
  end

  assign irq     = active;
  assign irq_lvl = active ? cur : 5'd0;
  assign irq_vec = active ? 16'hFFFE - {10'd0, cur, 1'b0} : 16'h0000;
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gdis,
  input logic        ack,
  input logic        irq,
  input logic [4:0]  irq_lvl,
  input logic [15:0] irq_vec
);
  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_lvl >= 5'd1 && irq_lvl <= 5'd17 && !irq_vec[0] &&
             irq_vec >= 16'hFFDC && irq_vec <= 16'hFFFC));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_lvl == 5'd0 && irq_vec == 16'h0000));

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && irq_lvl > 5'd1 && irq_lvl < 5'd17) |-> !$past(gdis));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> (irq && $stable(irq_lvl) && $stable(irq_vec)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);
endmodule

bind prio_vic prio_vic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gdis(gdis), .ack(ack),
  .irq(irq), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
);

// File: tb/prio_vic_test.sv
`timescale 1ns/1ps
module prio_vic_test;
  logic clk = 0, rst_n = 0;
  logic [10:0] pulse_in = '0;
  logic [4:0]  pin_in = '0;
  logic [7:0]  key_in = 8'hFF;
  logic brk_in = 0, gdis = 1, ack = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic [4:0] irq_lvl;
  logic [15:0] irq_vec;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  prio_vic uut (.clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .pin_in(pin_in),
    .key_in(key_in), .brk_in(brk_in), .gdis(gdis), .ack(ack), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .irq_lvl(irq_lvl),
    .irq_vec(irq_vec));

  // row: {pulse bit[3:0], select[1:0], expected level[4:0]}; level 0 = nothing
  localparam logic [10:0] TBL [14] = '{
    {4'd0, 2'd0, 5'd2},  {4'd1, 2'd0, 5'd3},  {4'd2, 2'd0, 5'd4},
    {4'd3, 2'd0, 5'd5},  {4'd4, 2'd1, 5'd8},  {4'd4, 2'd0, 5'd0},
    {4'd5, 2'd0, 5'd12}, {4'd6, 2'd0, 5'd13}, {4'd7, 2'd0, 5'd14},
    {4'd8, 2'd0, 5'd15}, {4'd9, 2'd0, 5'd16}, {4'd9, 2'd2, 5'd0},
    {4'd10, 2'd2, 5'd16}, {4'd10, 2'd0, 5'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1; cyc(1); wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic do_ack();
    ack = 1; cyc(1); ack = 0; cyc(1);
  endtask

  task automatic expect_lvl(input int lvl, input string tag);
    if (lvl == 0) chk(irq == 0, tag, irq, 0);
    else chk(irq && irq_lvl == lvl && irq_vec == 16'(16'hFFFE - 2 * lvl),
             tag, {irq_lvl, irq_vec}, {5'(lvl), 16'(16'hFFFE - 2 * lvl)});
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3); rst_n = 1; cyc(2);
    // R1 reset state
    expect_lvl(1, "R1 reset slot");
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), d);
      chk(d == 0, "R1 register cleared", d, 0);
    end
    do_ack();
    expect_lvl(0, "R1 cleared by ack");

    wreg(3'd2, 8'hFF); wreg(3'd3, 8'h7F); gdis = 0; cyc(1);
    // R2 R6 R9 vector table
    foreach (TBL[i]) begin
      wreg(3'd5, {6'd0, TBL[i][6:5]});
      pulse_in[TBL[i][10:7]] = 1; cyc(1); pulse_in = '0; cyc(3);
      expect_lvl(int'(TBL[i][4:0]), "R2 R9 table row");
      if (TBL[i][4:0] != 0) do_ack();
    end
    rreg(3'd6, d);
    chk(d == 8'h0E, "R10 capture of shared pulses", d, 8'h0E);
    wreg(3'd6, 8'h0F); rreg(3'd6, d);
    chk(d == 0, "R10 write-1 clears capture", d, 0);
    wreg(3'd5, 8'd0);

    // R3 R6: enable off, request held and readable, W1C
    wreg(3'd2, 8'hFB);
    pulse_in[2] = 1; cyc(1); pulse_in = '0; cyc(3);
    expect_lvl(0, "R3 disabled source masked");
    rreg(3'd0, d);
    chk(d == 8'h04, "R6 request bit held", d, 8'h04);
    wreg(3'd0, 8'h04); rreg(3'd0, d);
    chk(d == 0, "R6 write-1 clears request", d, 0);
    wreg(3'd2, 8'hFF);

    // R4 priority
    pulse_in[8] = 1; pulse_in[1] = 1; cyc(1); pulse_in = '0; cyc(3);
    expect_lvl(3, "R4 lower level first");
    do_ack(); cyc(1);
    expect_lvl(15, "R4 remaining level");
    do_ack();

    // R5 hold until ack, ack clears only serviced level
    pulse_in[7] = 1; cyc(1); pulse_in = '0; cyc(3);
    pulse_in[0] = 1; cyc(1); pulse_in = '0; cyc(3);
    expect_lvl(14, "R5 held despite higher arrival");
    do_ack(); cyc(1);
    expect_lvl(2, "R5 other request survives ack");
    do_ack();

    // R11 R3 break passes gdis, maskable does not
    gdis = 1;
    pulse_in[0] = 1; brk_in = 1; cyc(1); pulse_in = '0; brk_in = 0; cyc(3);
    expect_lvl(17, "R11 break with gdis set");
    do_ack(); cyc(2);
    expect_lvl(0, "R3 gdis masks pending");
    gdis = 0; cyc(3);
    expect_lvl(2, "R3 released when gdis clear");
    do_ack();

    // R7 pin polarity
    pin_in[0] = 1; cyc(6);
    expect_lvl(0, "R7 rising ignored at polarity 0");
    pin_in[0] = 0; cyc(6);
    expect_lvl(6, "R7 falling edge level 6");
    do_ack();
    wreg(3'd4, 8'h10);
    pin_in[4] = 1; cyc(6);
    expect_lvl(11, "R7 rising edge level 11");
    do_ack();
    pin_in[4] = 0; cyc(6);
    expect_lvl(0, "R7 falling ignored at polarity 1");

    // R8 key event and R10 capture
    key_in = 8'hEF; cyc(6);
    expect_lvl(8, "R8 key falling AND");
    do_ack();
    rreg(3'd6, d);
    chk(d == 8'h01, "R10 key capture bit", d, 8'h01);
    key_in = 8'hFF; cyc(6);
    expect_lvl(0, "R8 key rising ignored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule